// File: doc/BRIEF.md
# Latch-Array Upset Test Sequencer

This block runs an upset test on an array of storage cells placed under a particle beam. The cells sit in several columns, one memory flavour per column, and are reached through a serial chain as long as a column. Once started, the sequencer loads a bit pattern into the chain one bit per serial clock and commits it with a write strobe into the column chosen by the host. It then waits for the beam. When the end of a spill is signalled, it recaptures the cell contents into the chain and shifts them back out, comparing each bit with the bit that was written to the same cell.

The mismatches of each spill go into a saturating running total. Saturating counters also record the number of completed spills and the number of spills that had at least one upset. A histogram with one counter per cell position shows which cells flipped, and the host reads it through a small address port. After each readback the sequencer goes straight back to writing the same pattern. It keeps one acquisition per spill until the host aborts it.

Top module: `upset_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `armed`, `wr_strb`, `cap_strb`, `chain_sclk` and `stray_spill` are low, and all three counters read zero.
- R2: Each shift phase gives exactly CELLS pulses on `chain_sclk`. Each pulse is high for one cycle and `chain_sdi` holds steady while it is high. The bit for cell CELLS-1 goes first and the bit for cell 0 goes last, so after the write strobe cell i holds pattern bit i.
- R3: `pat_sel` picks the pattern. 0 gives all zeros, 1 gives all ones, 2 gives `host_pat` with bit i going to cell i, and 3 gives a checkerboard in which cell i holds i mod 2.
- R4: `wr_strb` and `cap_strb` are each one cycle wide. `chain_sclk` is low in every strobe cycle. The write strobe comes only after the last shift-in pulse, and the capture strobe comes before any readout pulse.
- R5: After the write strobe the block holds `armed` high until `spill_end` arrives. It then issues the capture strobe and CELLS readout pulses. `chain_sdo` is sampled at the clock edge that ends each high cycle of `chain_sclk`, and the first bit sampled belongs to cell CELLS-1.
- R6: The number of readback bits that differ from the written pattern is added to `err_total`, which saturates at 2^CNT_W-1 instead of wrapping.
- R7: Each completed readback adds one to `spill_total`. A readback with at least one mismatch also adds one to `bad_spills`. Both counters saturate at 2^CNT_W-1.
- R8: Each mismatching cell adds one to that cell's histogram counter, which saturates at 2^HIST_W-1. `hist_data` shows the counter at `hist_addr` one clock after the address is presented.
- R9: A `spill_end` that arrives while the block is not armed causes no capture and leaves the counters unchanged. It sets the sticky flag `stray_spill`.
- R10: `abort` returns the block to idle on the next edge from any state. No strobe or serial pulse follows, and the counters keep their values, so a partly read spill is not counted.
- R11: A `start` accepted in idle clears the counters, the sticky flag and the histogram, and latches the pattern and the column. A `start` while busy is ignored.
- R12: After each readback the block rewrites the same pattern to the same column and arms again without host action.
- R13: `chain_col` shows the column latched at start and holds it for the whole run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| abort | input | 1 | Synchronous return to idle |
| pat_sel | input | 2 | Pattern choice |
| host_pat | input | CELLS | Custom pattern, bit i for cell i |
| col_sel | input | $clog2(COLS) | Column to test |
| spill_end | input | 1 | Beam spill finished |
| chain_sdo | input | 1 | Serial data returned by the chain |
| chain_sdi | output | 1 | Serial data into the chain |
| chain_sclk | output | 1 | Serial clock pulse to the chain |
| chain_col | output | $clog2(COLS) | Column addressed by the strobes |
| wr_strb | output | 1 | Commit chain into the column |
| cap_strb | output | 1 | Load column contents into the chain |
| armed | output | 1 | Waiting for a spill |
| busy | output | 1 | A run is active |
| stray_spill | output | 1 | Sticky: spill end seen while not armed |
| err_total | output | CNT_W | Saturating mismatch total |
| spill_total | output | CNT_W | Saturating count of completed spills |
| bad_spills | output | CNT_W | Saturating count of spills with an upset |
| hist_addr | input | $clog2(CELLS) | Histogram read address |
| hist_data | output | HIST_W | Histogram counter at that address |

## Verification
The bench models the chain and the columns, flips chosen cells while the block is armed, and predicts every counter and histogram value by arithmetic. It aims at bit order: a reversed chain would put pattern bit i into cell CELLS-1-i and return nonzero error counts for the asymmetric custom and checkerboard patterns. It also drives every counter past its limit. A wrapping adder would show a small total after the error and spill counts overflow, and a histogram without saturation would show the same. It aborts midway through a readout and sends spill ends while idle and while shifting. A design that counted the partial spill, captured on a stray trigger, or kept the stray flag across a new start would give counts or a cell image that differ from the prediction.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_CLR, S_SHIN, S_WR, S_WAIT, S_CAP, S_SHOUT, S_CNT
  } seq_state_t;

  localparam logic [1:0] PAT_ZERO  = 2'd0;
  localparam logic [1:0] PAT_ONE   = 2'd1;
  localparam logic [1:0] PAT_HOST  = 2'd2;
  localparam logic [1:0] PAT_CHECK = 2'd3;
endpackage

// File: rtl/useq_shifter.sv
module useq_shifter #(
  parameter int CELLS = 80,
  localparam int IW = (CELLS > 1) ? $clog2(CELLS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             kill,
  input  logic             go,
  input  logic             rd_i,
  input  logic [CELLS-1:0] pat_i,
  input  logic             sdo_i,
  output logic             sclk_o,
  output logic             sdi_o,
  output logic             done_o,
  output logic             rx_v_o,
  output logic             rx_bit_o,
  output logic [IW-1:0]    rx_cell_o
);
  localparam logic [IW-1:0] LAST = IW'(CELLS - 1);

  logic          active, ph, rd_q;
  logic [IW-1:0] cnt, rxn;

  always_ff @(posedge clk) begin
    if (rst || kill) begin
      active    <= 1'b0;
      ph        <= 1'b0;
      rd_q      <= 1'b0;
      cnt       <= '0;
      rxn       <= '0;
      sclk_o    <= 1'b0;
      sdi_o     <= 1'b0;
      done_o    <= 1'b0;
      rx_v_o    <= 1'b0;
      rx_bit_o  <= 1'b0;
      rx_cell_o <= '0;
    end else begin
      done_o <= 1'b0;
      rx_v_o <= 1'b0;
      sclk_o <= active && ph;
      if (go) begin
        active <= 1'b1;
        ph     <= 1'b0;
        cnt    <= '0;
        rxn    <= '0;
        rd_q   <= rd_i;
      end else if (active) begin
        ph <= ~ph;
        if (!ph) begin
          sdi_o <= rd_q ? 1'b0 : pat_i[LAST - cnt];
        end else begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) active <= 1'b0;
        end
      end else begin
        sdi_o <= 1'b0;
      end
      if (sclk_o) begin
        rxn <= rxn + 1'b1;
        if (rxn == LAST) done_o <= 1'b1;
        if (rd_q) begin
          rx_v_o    <= 1'b1;
          rx_bit_o  <= sdo_i;
          rx_cell_o <= LAST - rxn;
        end
      end
    end
  end

  AST_SCLK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    sclk_o |=> !sclk_o); // R2
  AST_SDI_STEADY: assert property (@(posedge clk) disable iff (rst)
    (sclk_o && !$past(kill)) |-> $stable(sdi_o)); // R2
endmodule

// File: rtl/useq_tally.sv
module useq_tally #(
  parameter int CELLS = 80,
  parameter int CNT_W = 16,
  localparam int EW = $clog2(CELLS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             drop_i,
  input  logic             hit_i,
  input  logic             commit_i,
  output logic [CNT_W-1:0] err_o,
  output logic [CNT_W-1:0] spill_o,
  output logic [CNT_W-1:0] bad_o
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [EW-1:0]  cyc_q;
  logic [CNT_W:0] sum;

  assign sum = {1'b0, err_o} + (CNT_W+1)'(cyc_q);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cyc_q   <= '0;
      err_o   <= '0;
      spill_o <= '0;
      bad_o   <= '0;
    end else if (drop_i) begin
      cyc_q <= '0;
    end else if (commit_i) begin
      cyc_q   <= '0;
      err_o   <= sum[CNT_W] ? MAXV : sum[CNT_W-1:0];
      if (spill_o != MAXV) spill_o <= spill_o + 1'b1;
      if (cyc_q != '0 && bad_o != MAXV) bad_o <= bad_o + 1'b1;
    end else if (hit_i) begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

  AST_ERR_NO_DROP: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> (err_o >= $past(err_o))); // R6
  AST_BAD_WITHIN_SPILLS: assert property (@(posedge clk) disable iff (rst)
    bad_o <= spill_o); // R7
endmodule

// File: rtl/useq_hist.sv
module useq_hist #(
  parameter int CELLS  = 80,
  parameter int HIST_W = 16,
  localparam int IW = (CELLS > 1) ? $clog2(CELLS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_we,
  input  logic [IW-1:0]     clr_addr,
  input  logic              inc_v,
  input  logic [IW-1:0]     inc_addr,
  input  logic [IW-1:0]     rd_addr,
  output logic [HIST_W-1:0] rd_data
);
  localparam logic [HIST_W-1:0] HMAX = {HIST_W{1'b1}};

  logic [HIST_W-1:0] mem [CELLS];
  logic [HIST_W-1:0] old_q;
  logic [IW-1:0]     a1_q;
  logic              v1_q;

  always_ff @(posedge clk) begin
    if (rst) v1_q <= 1'b0;
    else     v1_q <= inc_v;
  end

  always_ff @(posedge clk) begin
    if (inc_v) begin
      a1_q  <= inc_addr;
      old_q <= mem[inc_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (clr_we)    mem[clr_addr] <= '0;
    else if (v1_q) mem[a1_q] <= (old_q == HMAX) ? old_q : old_q + 1'b1;
  end

  always_ff @(posedge clk) rd_data <= mem[rd_addr];

  AST_HIST_SPACED: assert property (@(posedge clk) disable iff (rst)
    inc_v |=> !inc_v); // R8
endmodule

// File: rtl/upset_seq.sv
module upset_seq
  import useq_pkg::*;
#(
  parameter int CELLS  = 80,
  parameter int COLS   = 8,
  parameter int CNT_W  = 16,
  parameter int HIST_W = 16,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int IW = (CELLS > 1) ? $clog2(CELLS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              abort,
  input  logic [1:0]        pat_sel,
  input  logic [CELLS-1:0]  host_pat,
  input  logic [CW-1:0]     col_sel,
  input  logic              spill_end,
  input  logic              chain_sdo,
  output logic              chain_sdi,
  output logic              chain_sclk,
  output logic [CW-1:0]     chain_col,
  output logic              wr_strb,
  output logic              cap_strb,
  output logic              armed,
  output logic              busy,
  output logic              stray_spill,
  output logic [CNT_W-1:0]  err_total,
  output logic [CNT_W-1:0]  spill_total,
  output logic [CNT_W-1:0]  bad_spills,
  input  logic [IW-1:0]     hist_addr,
  output logic [HIST_W-1:0] hist_data
);
  localparam logic [IW-1:0] LAST = IW'(CELLS - 1);

  seq_state_t       state, nxt;
  logic [CELLS-1:0] check_pat, sel_pat, pat_q;
  logic [IW-1:0]    clr_cnt;
  logic             accept, go, go_rd, sh_done;
  logic             rx_v, rx_bit, mism;
  logic [IW-1:0]    rx_cell;

  for (genvar g = 0; g < CELLS; g++) begin : g_check
    assign check_pat[g] = (g % 2 == 1);
  end

  always_comb begin
    unique case (pat_sel)
      PAT_ZERO:  sel_pat = '0;
      PAT_ONE:   sel_pat = '1;
      PAT_HOST:  sel_pat = host_pat;
      default:   sel_pat = check_pat;
    endcase
  end

  assign accept = (state == S_IDLE) && start && !abort;

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:  if (start) nxt = S_CLR;
      S_CLR:   if (clr_cnt == LAST) nxt = S_SHIN;
      S_SHIN:  if (sh_done) nxt = S_WR;
      S_WR:    nxt = S_WAIT;
      S_WAIT:  if (spill_end) nxt = S_CAP;
      S_CAP:   nxt = S_SHOUT;
      S_SHOUT: if (sh_done) nxt = S_CNT;
      S_CNT:   nxt = S_SHIN;
      default: nxt = S_IDLE;
    endcase
    if (abort) nxt = S_IDLE;
  end

  assign go    = ((nxt == S_SHIN) && (state != S_SHIN)) ||
                 ((nxt == S_SHOUT) && (state != S_SHOUT));
  assign go_rd = (nxt == S_SHOUT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      busy        <= 1'b0;
      armed       <= 1'b0;
      wr_strb     <= 1'b0;
      cap_strb    <= 1'b0;
      stray_spill <= 1'b0;
      clr_cnt     <= '0;
      pat_q       <= '0;
      chain_col   <= '0;
    end else begin
      state    <= nxt;
      busy     <= (nxt != S_IDLE);
      armed    <= (nxt == S_WAIT);
      wr_strb  <= (nxt == S_WR);
      cap_strb <= (nxt == S_CAP);
      clr_cnt  <= (state == S_CLR) ? clr_cnt + 1'b1 : '0;
      stray_spill <= (accept ? 1'b0 : stray_spill) |
                     (spill_end && (state != S_WAIT));
      if (accept) begin
        pat_q     <= sel_pat;
        chain_col <= col_sel;
      end
    end
  end

  useq_shifter #(.CELLS(CELLS)) u_shift (
    .clk(clk), .rst(rst), .kill(abort), .go(go), .rd_i(go_rd),
    .pat_i(pat_q), .sdo_i(chain_sdo), .sclk_o(chain_sclk),
    .sdi_o(chain_sdi), .done_o(sh_done), .rx_v_o(rx_v),
    .rx_bit_o(rx_bit), .rx_cell_o(rx_cell)
  );

  assign mism = rx_v && (rx_bit != pat_q[rx_cell]);

  useq_tally #(.CELLS(CELLS), .CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst(rst), .clr_i(accept), .drop_i(abort), .hit_i(mism),
    .commit_i(state == S_CNT), .err_o(err_total), .spill_o(spill_total),
    .bad_o(bad_spills)
  );

  useq_hist #(.CELLS(CELLS), .HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst(rst), .clr_we(state == S_CLR), .clr_addr(clr_cnt),
    .inc_v(mism), .inc_addr(rx_cell), .rd_addr(hist_addr),
    .rd_data(hist_data)
  );

  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wr_strb |=> !wr_strb); // R4
  AST_CAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    cap_strb |=> !cap_strb); // R4
  AST_NO_SCLK_IN_STROBE: assert property (@(posedge clk) disable iff (rst)
    (wr_strb || cap_strb) |-> !chain_sclk); // R4
  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!busy && !armed && !wr_strb && !cap_strb)); // R10
  AST_STRAY_STICKY: assert property (@(posedge clk) disable iff (rst)
    (spill_end && state != S_WAIT) |=> stray_spill); // R9
  AST_COL_HELD: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE) |=> $stable(chain_col)); // R13
endmodule

// File: tb/upset_seq_tb.sv
module upset_seq_tb;
  localparam int CELLS = 8, COLS = 4, CNT_W = 7, HIST_W = 4;
  localparam int MAXC = 127, MAXH = 15;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, abort = 1'b0, spill_end = 1'b0;
  logic [1:0] pat_sel = '0;
  logic [CELLS-1:0] host_pat = '0;
  logic [1:0] col_sel = '0;
  logic chain_sdo, chain_sdi, chain_sclk, wr_strb, cap_strb, armed, busy, stray_spill;
  logic [1:0] chain_col;
  logic [CNT_W-1:0] err_total, spill_total, bad_spills;
  logic [2:0] hist_addr = '0;
  logic [HIST_W-1:0] hist_data;

  always #4 clk = ~clk;

  upset_seq #(.CELLS(CELLS), .COLS(COLS), .CNT_W(CNT_W), .HIST_W(HIST_W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .abort(abort), .pat_sel(pat_sel),
    .host_pat(host_pat), .col_sel(col_sel), .spill_end(spill_end),
    .chain_sdo(chain_sdo), .chain_sdi(chain_sdi), .chain_sclk(chain_sclk),
    .chain_col(chain_col), .wr_strb(wr_strb), .cap_strb(cap_strb),
    .armed(armed), .busy(busy), .stray_spill(stray_spill),
    .err_total(err_total), .spill_total(spill_total), .bad_spills(bad_spills),
    .hist_addr(hist_addr), .hist_data(hist_data)
  );

  // chain and column model
  logic [CELLS-1:0] chain = '0;
  logic [CELLS-1:0] cells [COLS];
  logic inj_go = 1'b0;
  logic [CELLS-1:0] inj_mask = '0;
  int inj_col = 0;
  assign chain_sdo = chain[CELLS-1];
  initial for (int i = 0; i < COLS; i++) cells[i] = '0;

  always @(posedge clk) begin
    if (chain_sclk) chain <= {chain[CELLS-2:0], chain_sdi};
    if (cap_strb) chain <= cells[chain_col];
    if (wr_strb) cells[chain_col] <= chain;
    if (inj_go) cells[inj_col] <= cells[inj_col] ^ inj_mask;
  end

  // monitors
  int pulses = 0, wr_seen = 0, wr_at = 0, cap_seen = 0, cap_at = 0, viol = 0;
  logic wr_prev = 1'b0, cap_prev = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (wr_strb) begin wr_seen++; wr_at = pulses; if (chain_sclk || wr_prev) viol++; end
      if (cap_strb) begin cap_seen++; cap_at = pulses; if (chain_sclk || cap_prev) viol++; end
      if (chain_sclk) pulses++;
      wr_prev = wr_strb;
      cap_prev = cap_strb;
    end
  end

  int checks = 0, fails = 0;
  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", fails, checks + 1);
    $finish;
  end

  // expected model
  int cur_col = 0;
  logic [CELLS-1:0] cur_pat = '0;
  int e_err = 0, e_spill = 0, e_bad = 0;
  int hm [CELLS];

  function automatic logic [CELLS-1:0] exp_pat(int sel, logic [CELLS-1:0] cu);
    logic [CELLS-1:0] p;
    case (sel)
      0: p = '0;
      1: p = '1;
      2: p = cu;
      default: for (int i = 0; i < CELLS; i++) p[i] = (i % 2 == 1);
    endcase
    return p;
  endfunction

  task automatic wait_armed();
    while (!armed) @(negedge clk);
  endtask

  task automatic start_run(int sel, int col, logic [CELLS-1:0] cu);
    int p0, w0;
    @(negedge clk);
    pat_sel = 2'(sel); col_sel = 2'(col); host_pat = cu; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cur_col = col; cur_pat = exp_pat(sel, cu);
    e_err = 0; e_spill = 0; e_bad = 0;
    for (int i = 0; i < CELLS; i++) hm[i] = 0;
    p0 = pulses; w0 = wr_seen;
    wait_armed();
    chk("R2 shift-in pulse count", pulses - p0, CELLS);
    chk("R3 cell image after write", cells[cur_col], cur_pat);
    chk("R4 one write strobe", wr_seen - w0, 1);
    chk("R4 write after last pulse", wr_at - p0, CELLS);
    chk("R13 column latched", chain_col, col);
    chk("R11 counters cleared", err_total + spill_total + bad_spills, 0);
    chk("R11 stray flag cleared", stray_spill, 0);
  endtask

  task automatic do_spill(logic [CELLS-1:0] mask, bit quiet);
    int p0, c0, n;
    @(negedge clk);
    inj_col = cur_col; inj_mask = mask; inj_go = 1'b1;
    @(negedge clk);
    inj_go = 1'b0; spill_end = 1'b1;
    @(negedge clk);
    spill_end = 1'b0;
    p0 = pulses; c0 = cap_seen;
    wait_armed();
    n = $countones(mask);
    e_err = (e_err + n > MAXC) ? MAXC : e_err + n;
    if (e_spill < MAXC) e_spill++;
    if (n != 0 && e_bad < MAXC) e_bad++;
    for (int i = 0; i < CELLS; i++) if (mask[i] && hm[i] < MAXH) hm[i]++;
    if (!quiet) begin
      chk("R5 one capture strobe", cap_seen - c0, 1);
      chk("R5 readout plus rewrite pulses", pulses - p0, 2 * CELLS);
      chk("R12 pattern rewritten", cells[cur_col], cur_pat);
    end
    chk("R6 error total", err_total, e_err);
    chk("R7 spill total", spill_total, e_spill);
    chk("R7 bad spills", bad_spills, e_bad);
  endtask

  task automatic check_hist();
    for (int i = 0; i < CELLS; i++) begin
      hist_addr = 3'(i);
      @(negedge clk);
      chk("R8 histogram cell", hist_data, hm[i]);
    end
  endtask

  task automatic abort_mid_readout();
    int e0, s0, b0, p0;
    e0 = err_total; s0 = spill_total; b0 = bad_spills;
    @(negedge clk);
    inj_col = cur_col; inj_mask = '1; inj_go = 1'b1;
    @(negedge clk);
    inj_go = 1'b0; spill_end = 1'b1;
    @(negedge clk);
    spill_end = 1'b0;
    repeat (8) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk("R10 idle after abort", busy, 0);
    p0 = pulses;
    repeat (20) @(negedge clk);
    chk("R10 no pulses after abort", pulses - p0, 0);
    chk("R10 errors kept", err_total, e0);
    chk("R10 spills kept", spill_total, s0);
    chk("R10 bad spills kept", bad_spills, b0);
    // stray trigger while idle
    spill_end = 1'b1;
    @(negedge clk);
    spill_end = 1'b0;
    @(negedge clk);
    chk("R9 stray flag set in idle", stray_spill, 1);
    chk("R9 stray changes no count", spill_total, s0);
    chk("R9 stray causes no run", busy, 0);
  endtask

  initial begin
    int c0, v0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 armed", armed, 0);
    chk("R1 strobes", wr_strb | cap_strb | chain_sclk, 0);
    chk("R1 stray", stray_spill, 0);
    chk("R1 counters", err_total + spill_total + bad_spills, 0);

    for (int sel = 0; sel < 4; sel++) begin
      start_run(sel, sel, 8'hB4 ^ 8'(sel));
      for (int k = 0; k < 5; k++)
        do_spill((k == 0) ? 8'h00 : 8'(k * 83 + sel * 29), 1'b0);
      check_hist();
      // start while busy is ignored
      @(negedge clk);
      col_sel = 2'(sel + 1); pat_sel = 2'(sel + 1); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      chk("R11 start while busy keeps column", chain_col, sel);
      chk("R11 start while busy keeps counts", spill_total, e_spill);
      chk("R11 still armed", armed, 1);
      do_spill(8'h01, 1'b0);
      abort_mid_readout();
    end

    // stray trigger during shifting, then saturation run
    @(negedge clk);
    pat_sel = 2'd1; col_sel = 2'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cur_col = 3; cur_pat = '1; e_err = 0; e_spill = 0; e_bad = 0;
    for (int i = 0; i < CELLS; i++) hm[i] = 0;
    c0 = cap_seen;
    repeat (12) @(negedge clk);
    spill_end = 1'b1;
    @(negedge clk);
    spill_end = 1'b0;
    wait_armed();
    chk("R9 stray while shifting sets flag", stray_spill, 1);
    chk("R9 stray while shifting no capture", cap_seen - c0, 0);
    chk("R9 stray while shifting no spill", spill_total, 0);
    chk("R2 pattern intact after stray", cells[3], 8'hFF);
    for (int k = 0; k < 130; k++) do_spill((k < 20) ? 8'hFF : 8'h00, 1'b1);
    chk("R6 error total saturated", err_total, MAXC);
    chk("R7 spill total saturated", spill_total, MAXC);
    chk("R7 bad spills", bad_spills, 20);
    check_hist();
    v0 = viol;
    chk("R4 strobe width and serial quiet", v0, 0);
    @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk("R10 idle at end", busy, 0);
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end
endmodule